// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank State Tracker

This block sits on the device side of a two-die DDR SDRAM interface. It samples the command pins on each rising clock edge: one active-low select per die, the three strobes for row, column and write, clock enable, a bank address and the address bus. It turns them into one decoded command per die. For every die it keeps the open or idle state of each internal bank. It holds the base and extended mode register values, and it raises a one-cycle error flag whenever a command breaks the bank or select rules.

Each die is commanded on its own through its select line. Mode-register loads are shared and are only accepted when both dies are selected together. Reads and writes may ask for auto-precharge on the same address bit that picks a single-bank or all-bank precharge. A bank given auto-precharge returns to idle by itself once its burst, whose length comes from the stored mode register, has run out.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: Commands are sampled on the rising edge. With the select low, {RAS#,CAS#,WE#} = 011 is ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH, 000 MODE SET and 111 NOP. `dec_cmd` holds one 3-bit code per die (die d at bits 3d+2..3d), with NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5, MODE SET=6 and UNSUPPORTED=7. It is registered on the edge where the command is sampled. REFRESH changes no bank state.
- R2: A die whose select is sampled high decodes NOP, and nothing sent in that cycle changes its banks.
- R3: While `cke` is sampled low, every die decodes NOP. No bank opens or closes by command and neither mode register changes.
- R4: ACTIVE to an idle bank opens bank `ba` of the selected die. The bank shows in `bank_open` bit 4d+ba.
- R5: PRECHARGE with `addr[8]` low closes only bank `ba` of the selected die. With `addr[8]` high it closes all four banks of that die.
- R6: MODE SET with both selects low and `ba`=0 loads `addr` into `mode_reg`. With `ba`=1 it loads `addr` into `ext_mode_reg`. With `ba`=2 or 3 it loads nothing and raises `err_flag`.
- R7: MODE SET with exactly one select low raises `err_flag` and changes neither mode register nor any bank.
- R8: READ or WRITE to an idle bank, or ACTIVE to an open bank, raises `err_flag` for one cycle and leaves the bank state as it was.
- R9: READ or WRITE to an open bank with `addr[8]` high closes that bank N cycles after the command edge. N is 2 when `mode_reg[2:0]`=2, 4 when it is 3, and 1 otherwise. A PRECHARGE that hits the bank cancels the countdown. A later READ or WRITE to the bank restarts it, or clears it when `addr[8]` is low.
- R10: With the select low and {RAS#,CAS#,WE#} = 110, the die decodes UNSUPPORTED and raises `err_flag`.
- R11: After reset all banks are idle, both mode registers are zero, `dec_cmd` is all NOP and `err_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low suppresses all commands |
| cs_n | input | 2 | Active-low select, one per die |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address / mode register selector |
| addr | input | 12 | Row, column, auto-precharge / all-bank bit (8), opcode |
| dec_cmd | output | 6 | Registered decoded command per die, 3 bits each |
| bank_open | output | 8 | Open flag per bank, bit 4*die+bank |
| err_flag | output | 1 | One-cycle flag for an illegal command |
| mode_reg | output | 12 | Stored base mode register |
| ext_mode_reg | output | 12 | Stored extended mode register |

## Verification
The bench builds the block with its default parameters: two dies, a 2-bit bank address for four banks per die, a 12-bit address and bit 8 as the precharge/auto-precharge bit. This default reaches select combinations where one die is commanded while the other is deselected, the split mode-set case, and all three auto-precharge countdown lengths chosen through the stored burst code. Directed steps cover the cancel and restart orderings of a running countdown. A long pseudo-random phase then mixes commands, selects, clock-enable drops and burst codes against the behavioural model.

// File: rtl/ddr_cmd_pkg.sv
// Package: shared command codes and burst-length helpers for the DDR
// command tracker. Assumes burst code 2 -> 4 beats, 3 -> 8 beats, others 2.
package ddr_cmd_pkg;

    localparam int AP_CNT_W = 3;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6,
        CMD_ILL = 3'd7
    } cmd_e;

    // Clock cycles a double-rate burst occupies for a given burst code.
    function automatic logic [AP_CNT_W-1:0] burst_clocks(input logic [2:0] code);
        case (code)
            3'd2:    burst_clocks = AP_CNT_W'(2);
            3'd3:    burst_clocks = AP_CNT_W'(4);
            default: burst_clocks = AP_CNT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
// Module: ddr_cmd_decode
// Turns the sampled strobe pins of one die into a command code.
// Assumes: inputs are the values present at the rising edge; a high select
// or low clock enable yields NOP. Purely combinational.
module ddr_cmd_decode
    import ddr_cmd_pkg::*;
(
    input  logic cke,
    input  logic sel_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Map the strobe triple onto a command when the die is addressed.
    always_comb begin
        cmd = CMD_NOP;
        if (cke && !sel_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                3'b111:  cmd = CMD_NOP;
                default: cmd = CMD_ILL;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_ctrl.sv
// Module: ddr_bank_ctrl
// Open/idle state and auto-precharge countdown for the banks of one die.
// Assumes: cmd is already gated by select and clock enable; bank count is
// 2**BA_W; illegal bank commands leave state untouched and raise err_o.
module ddr_bank_ctrl
    import ddr_cmd_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  cmd_e                     cmd,
    input  logic [BA_W-1:0]          ba,
    input  logic                     ap,
    input  logic [AP_CNT_W-1:0]      burst_clks,
    output logic [(1<<BA_W)-1:0]     open_o,
    output logic                     err_o
);

    localparam int NUM_BANKS = 1 << BA_W;

    logic [NUM_BANKS-1:0] open_q;
    logic                 cur_open;

    assign open_o   = open_q;
    assign cur_open = open_q[ba];

    // Flag commands that conflict with the addressed bank's state.
    always_comb begin
        err_o = 1'b0;
        if ((cmd == CMD_RD || cmd == CMD_WR) && !cur_open) err_o = 1'b1;
        if (cmd == CMD_ACT && cur_open)                    err_o = 1'b1;
        if (cmd == CMD_ILL)                                err_o = 1'b1;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [BA_W-1:0] BIDX = BA_W'(b);
        logic                hit;
        logic [AP_CNT_W-1:0] cnt_q;

        assign hit = (ba == BIDX);

        // Per-bank state: command effects first, then countdown to close.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
                cnt_q     <= '0;
            end else if (cmd == CMD_ACT && hit && !open_q[b]) begin
                open_q[b] <= 1'b1;
                cnt_q     <= '0;
            end else if (cmd == CMD_PRE && (ap || hit)) begin
                open_q[b] <= 1'b0;
                cnt_q     <= '0;
            end else if ((cmd == CMD_RD || cmd == CMD_WR) && hit && open_q[b]) begin
                cnt_q     <= ap ? burst_clks : '0;
            end else if (cnt_q != '0) begin
                if (cnt_q == AP_CNT_W'(1)) open_q[b] <= 1'b0;
                cnt_q <= cnt_q - AP_CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/ddr_mode_store.sv
// Module: ddr_mode_store
// Holds the base and extended mode registers shared by all dies.
// Assumes: a load is legal only when every die decodes MODE SET in the
// same cycle; selector 0 is base, 1 is extended, others are rejected.
module ddr_mode_store #(
    parameter int BA_W   = 2,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              all_mrs,
    input  logic              any_mrs,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] mr_o,
    output logic [ADDR_W-1:0] emr_o,
    output logic              err_o
);

    localparam logic [BA_W-1:0] SEL_BASE = BA_W'(0);
    localparam logic [BA_W-1:0] SEL_EXT  = BA_W'(1);

    logic sel_ok;

    assign sel_ok = (ba == SEL_BASE) || (ba == SEL_EXT);

    // Reject split-select loads and unknown register selectors.
    always_comb begin
        err_o = any_mrs && (!all_mrs || !sel_ok);
    end

    // Capture the opcode into the selected register on a legal load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mr_o  <= '0;
            emr_o <= '0;
        end else if (all_mrs) begin
            if (ba == SEL_BASE) mr_o  <= addr;
            if (ba == SEL_EXT)  emr_o <= addr;
        end
    end

endmodule

// File: rtl/ddr_cmd_tracker.sv
// Module: ddr_cmd_tracker (top)
// Decodes per-die commands of a multi-die DDR SDRAM, tracks every bank's
// open state, stores the mode registers and flags illegal commands.
// Assumes: all pins sampled on the rising edge; AP_BIT is both the
// precharge-all bit and the auto-precharge bit; outputs are registered.
module ddr_cmd_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int NUM_DIES = 2,
    parameter int BA_W     = 2,
    parameter int ADDR_W   = 12,
    parameter int AP_BIT   = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cke,
    input  logic [NUM_DIES-1:0]                 cs_n,
    input  logic                                ras_n,
    input  logic                                cas_n,
    input  logic                                we_n,
    input  logic [BA_W-1:0]                     ba,
    input  logic [ADDR_W-1:0]                   addr,
    output logic [NUM_DIES*3-1:0]               dec_cmd,
    output logic [NUM_DIES*(1<<BA_W)-1:0]       bank_open,
    output logic                                err_flag,
    output logic [ADDR_W-1:0]                   mode_reg,
    output logic [ADDR_W-1:0]                   ext_mode_reg
);

    localparam int NUM_BANKS = 1 << BA_W;

    cmd_e                 die_cmd [NUM_DIES];
    logic [NUM_DIES-1:0]  die_err;
    logic [NUM_DIES-1:0]  is_mrs;
    logic [AP_CNT_W-1:0]  burst_clks;
    logic                 mode_err;

    assign burst_clks = burst_clocks(mode_reg[2:0]);

    for (genvar d = 0; d < NUM_DIES; d++) begin : g_die
        ddr_cmd_decode u_dec (
            .cke   (cke),
            .sel_n (cs_n[d]),
            .ras_n (ras_n),
            .cas_n (cas_n),
            .we_n  (we_n),
            .cmd   (die_cmd[d])
        );

        ddr_bank_ctrl #(.BA_W(BA_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd        (die_cmd[d]),
            .ba         (ba),
            .ap         (addr[AP_BIT]),
            .burst_clks (burst_clks),
            .open_o     (bank_open[d*NUM_BANKS +: NUM_BANKS]),
            .err_o      (die_err[d])
        );

        assign is_mrs[d] = (die_cmd[d] == CMD_MRS);
    end

    ddr_mode_store #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .all_mrs (&is_mrs),
        .any_mrs (|is_mrs),
        .ba      (ba),
        .addr    (addr),
        .mr_o    (mode_reg),
        .emr_o   (ext_mode_reg),
        .err_o   (mode_err)
    );

    // Register the decoded commands and the combined error for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_cmd  <= '0;
            err_flag <= 1'b0;
        end else begin
            for (int d = 0; d < NUM_DIES; d++) dec_cmd[d*3 +: 3] <= die_cmd[d];
            err_flag <= (|die_err) | mode_err;
        end
    end

endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
// Module: ddr_cmd_tracker_chk
// Port-level temporal checks for ddr_cmd_tracker, attached by bind.
// Assumes default-style layout: die 0 owns the low bank_open bits.
module ddr_cmd_tracker_chk #(
    parameter int NUM_DIES = 2,
    parameter int BA_W     = 2,
    parameter int ADDR_W   = 12,
    parameter int AP_BIT   = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cke,
    input logic [NUM_DIES-1:0]           cs_n,
    input logic                          ras_n,
    input logic                          cas_n,
    input logic                          we_n,
    input logic [BA_W-1:0]               ba,
    input logic [ADDR_W-1:0]             addr,
    input logic [NUM_DIES*3-1:0]         dec_cmd,
    input logic [NUM_DIES*(1<<BA_W)-1:0] bank_open,
    input logic                          err_flag,
    input logic [ADDR_W-1:0]             mode_reg,
    input logic [ADDR_W-1:0]             ext_mode_reg
);

    localparam int NUM_BANKS = 1 << BA_W;

    logic [NUM_BANKS-1:0] die0_open;
    logic                 die0_sel;
    logic [2:0]           strobes;

    assign die0_open = bank_open[NUM_BANKS-1:0];
    assign die0_sel  = cke && !cs_n[0];
    assign strobes   = {ras_n, cas_n, we_n};

    AST_DESELECT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && cs_n[0]) |=> (dec_cmd[2:0] == 3'd0)); // R2

    AST_CKE_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (dec_cmd == '0 && $stable(mode_reg) && $stable(ext_mode_reg))); // R3

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (die0_sel && strobes == 3'b011 && !die0_open[ba]) |=> die0_open[$past(ba)]); // R4

    AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (die0_sel && strobes == 3'b010 && addr[AP_BIT]) |=> (die0_open == '0)); // R5

    AST_SPLIT_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && strobes == 3'b000 && cs_n != '0 && cs_n != '1)
        |=> (err_flag && $stable(mode_reg) && $stable(ext_mode_reg))); // R7

    AST_IDLE_ACCESS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (die0_sel && strobes == 3'b101 && !die0_open[ba]) |=> err_flag); // R8

    AST_UNSUPPORTED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (die0_sel && strobes == 3'b110) |=> (err_flag && dec_cmd[2:0] == 3'd7)); // R10

endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(
    .NUM_DIES (NUM_DIES),
    .BA_W     (BA_W),
    .ADDR_W   (ADDR_W),
    .AP_BIT   (AP_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke          (cke),
    .cs_n         (cs_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .ba           (ba),
    .addr         (addr),
    .dec_cmd      (dec_cmd),
    .bank_open    (bank_open),
    .err_flag     (err_flag),
    .mode_reg     (mode_reg),
    .ext_mode_reg (ext_mode_reg)
);

// File: tb/ddr_cmd_tracker_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the tracker, compared every clock.
module ddr_cmd_tracker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic [1:0]  cs_n = 2'b11;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic [5:0]  dec_cmd;
    logic [7:0]  bank_open;
    logic        err_flag;
    logic [11:0] mode_reg, ext_mode_reg;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int          m_open [2][4];
    int          m_cnt  [2][4];
    int          m_cmd  [2];
    bit          m_err;
    logic [11:0] m_mr, m_emr;

    always #2.5 clk = ~clk;

    ddr_cmd_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .dec_cmd(dec_cmd), .bank_open(bank_open), .err_flag(err_flag),
        .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg)
    );

    function automatic void model_reset();
        for (int d = 0; d < 2; d++) begin
            m_cmd[d] = 0;
            for (int b = 0; b < 4; b++) begin m_open[d][b] = 0; m_cnt[d][b] = 0; end
        end
        m_err = 0; m_mr = '0; m_emr = '0;
    endfunction

    // One rising edge of the specified behaviour.
    function automatic void model_step(input bit k, input bit [1:0] cs,
                                       input bit [2:0] rcw, input int bk,
                                       input bit [11:0] a);
        int len;
        int nm;
        bit apb;
        len = (m_mr[2:0] == 3'd2) ? 2 : (m_mr[2:0] == 3'd3) ? 4 : 1;
        apb = a[8];
        m_err = 0;
        nm = 0;
        for (int d = 0; d < 2; d++) begin
            int c;
            c = 0;
            if (k && !cs[d]) begin
                case (rcw)
                    3'b011: c = 1; 3'b101: c = 2; 3'b100: c = 3; 3'b010: c = 4;
                    3'b001: c = 5; 3'b000: c = 6; 3'b111: c = 0; default: c = 7;
                endcase
            end
            m_cmd[d] = c;
            if (c == 6) nm++;
            if (c == 7) m_err = 1;
            if ((c == 2 || c == 3) && m_open[d][bk] == 0) m_err = 1;
            if (c == 1 && m_open[d][bk] == 1) m_err = 1;
            for (int b = 0; b < 4; b++) begin
                if (c == 1 && b == bk && m_open[d][b] == 0) begin
                    m_open[d][b] = 1; m_cnt[d][b] = 0;
                end else if (c == 4 && (apb || b == bk)) begin
                    m_open[d][b] = 0; m_cnt[d][b] = 0;
                end else if ((c == 2 || c == 3) && b == bk && m_open[d][b] == 1) begin
                    m_cnt[d][b] = apb ? len : 0;
                end else if (m_cnt[d][b] > 0) begin
                    if (m_cnt[d][b] == 1) m_open[d][b] = 0;
                    m_cnt[d][b]--;
                end
            end
        end
        if (nm == 1) m_err = 1;
        else if (nm == 2) begin
            if (bk == 0) m_mr = a;
            else if (bk == 1) m_emr = a;
            else m_err = 1;
        end
    endfunction

    task automatic compare(input string tag);
        logic [5:0] e_cmd;
        logic [7:0] e_open;
        e_cmd = {m_cmd[1][2:0], m_cmd[0][2:0]};
        for (int d = 0; d < 2; d++)
            for (int b = 0; b < 4; b++) e_open[d*4+b] = (m_open[d][b] != 0);
        n_cmp++;
        if (dec_cmd !== e_cmd || bank_open !== e_open || err_flag !== m_err ||
            mode_reg !== m_mr || ext_mode_reg !== m_emr) begin
            n_bad++;
            $display("FAIL %s: got cmd=%h open=%h err=%b mr=%h emr=%h exp cmd=%h open=%h err=%b mr=%h emr=%h",
                     tag, dec_cmd, bank_open, err_flag, mode_reg, ext_mode_reg,
                     e_cmd, e_open, m_err, m_mr, m_emr);
        end
    endtask

    // Drive one command, advance the model and check after the edge.
    task automatic cyc(input bit k, input bit [1:0] cs, input bit [2:0] rcw,
                       input int bk, input bit [11:0] a, input string tag);
        @(negedge clk);
        cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = 2'(bk); addr = a;
        model_step(k, cs, rcw, bk, a);
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 2'b11, 3'b111, 0, 12'h000, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        compare("R11 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        // mode registers: BL code 2 -> two-cycle countdown
        cyc(1, 2'b00, 3'b000, 0, 12'h032, "R6 base mode load");
        cyc(1, 2'b00, 3'b000, 1, 12'h002, "R6 extended mode load");
        cyc(1, 2'b00, 3'b000, 2, 12'h7ff, "R6 bad selector");
        cyc(1, 2'b10, 3'b000, 0, 12'h555, "R7 split mode set");
        // bank activation and conflicts
        cyc(1, 2'b10, 3'b011, 1, 12'h123, "R4 activate die0 bank1");
        cyc(1, 2'b01, 3'b011, 1, 12'h045, "R4 activate die1 bank1");
        cyc(1, 2'b10, 3'b011, 1, 12'h000, "R8 activate open bank");
        cyc(1, 2'b10, 3'b101, 2, 12'h010, "R8 read idle bank");
        cyc(1, 2'b10, 3'b101, 1, 12'h010, "R1 read open bank");
        cyc(1, 2'b01, 3'b100, 1, 12'h110, "R9 write with auto-precharge");
        idle(3, "R9 countdown closes");
        cyc(1, 2'b11, 3'b011, 3, 12'h000, "R2 deselected activate");
        cyc(0, 2'b00, 3'b011, 3, 12'h000, "R3 clock enable low activate");
        cyc(0, 2'b00, 3'b000, 0, 12'h0ff, "R3 clock enable low mode set");
        cyc(1, 2'b10, 3'b110, 0, 12'h000, "R10 unsupported code");
        cyc(1, 2'b00, 3'b001, 0, 12'h000, "R1 refresh both dies");
        // single and all-bank precharge
        cyc(1, 2'b10, 3'b011, 0, 12'h000, "R4 open bank0");
        cyc(1, 2'b10, 3'b011, 2, 12'h000, "R4 open bank2");
        cyc(1, 2'b10, 3'b011, 3, 12'h000, "R4 open bank3");
        cyc(1, 2'b10, 3'b010, 2, 12'h000, "R5 precharge one bank");
        cyc(1, 2'b10, 3'b010, 0, 12'h100, "R5 precharge all banks");
        // longest countdown, cancel and restart
        cyc(1, 2'b00, 3'b000, 0, 12'h033, "R6 burst code 3");
        cyc(1, 2'b10, 3'b011, 1, 12'h000, "R9 open for cancel");
        cyc(1, 2'b10, 3'b101, 1, 12'h100, "R9 read auto-precharge");
        idle(2, "R9 counting");
        cyc(1, 2'b10, 3'b010, 1, 12'h000, "R9 precharge cancels");
        idle(2, "R9 after cancel");
        cyc(1, 2'b10, 3'b011, 1, 12'h000, "R9 reopen");
        cyc(1, 2'b10, 3'b101, 1, 12'h100, "R9 first auto-precharge");
        idle(2, "R9 counting");
        cyc(1, 2'b10, 3'b100, 1, 12'h100, "R9 restart countdown");
        idle(5, "R9 restarted close");
        cyc(1, 2'b10, 3'b011, 1, 12'h000, "R9 reopen again");
        cyc(1, 2'b10, 3'b101, 1, 12'h100, "R9 auto-precharge then clear");
        cyc(1, 2'b10, 3'b101, 1, 12'h000, "R9 plain read clears");
        idle(6, "R9 bank stays open");
        cyc(1, 2'b00, 3'b000, 0, 12'h031, "R9 burst code 1");
        cyc(1, 2'b10, 3'b101, 1, 12'h100, "R9 one-cycle countdown");
        idle(2, "R9 one-cycle closed");

        // mixed pseudo-random traffic
        void'($urandom(32'h5eed));
        for (int i = 0; i < 3000; i++) begin
            bit          k;
            bit [2:0]    rcw;
            bit [11:0]   a;
            k   = ($urandom % 16) != 0;
            rcw = 3'($urandom % 8);
            a   = 12'($urandom);
            if (rcw == 3'b000 && ($urandom % 4) != 0) a[11:3] = '0;
            cyc(k, 2'($urandom % 4), rcw, $urandom % 4, a, "R1/R4/R5/R8/R9 mixed");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule